// File: doc/BRIEF.md
# Perturb-and-Observe Converter Mode Selector

This block chooses the operating mode of a two-switch DC-DC converter that sits between a solar panel and a battery. A free-running sample counter sets when the block takes two snapshots of the panel. Each snapshot holds an 8-bit voltage code and the 16-bit product of that voltage code and the current code. Once per counter period, after the second snapshot, the block compares the two powers and the two voltages. It then drives a 2-bit mode decision to the downstream PWM driver: step-down (buck), step-up (boost), or both switches at a fixed ratio (buck-boost). The buck-boost mode means the panel sits at its maximum power point.

Mode encoding: 2'b00 = no decision yet, 2'b01 = buck, 2'b10 = boost, 2'b11 = buck-boost.

The sensor codes arrive on plain ports and are sampled directly, with no handshake. The inputs carry no back-pressure because the block reads them only at its two sample counts. The decision strobe is also a plain one-cycle pulse. A receiver that cannot take the decision on that cycle must read `mode` later: it holds its value until the next strobe.

Top module: `mppt_mode_sel`

## Requirements
- R1: While `rst_n` is low, `mode` is 2'b00, `mode_vld` is 0, and both `pwr_a` and `pwr_b` are 0. The sample counter restarts from 0.
- R2: The sample counter advances by one on every clock and wraps from 255 to 0. Snapshot A is taken at count 100 and snapshot B at count 200. With the counter at 0 after reset, `pwr_a` changes on the 101st rising edge after reset is released and `pwr_b` on the 201st. This repeats every 256 edges.
- R3: `pwr_a` and `pwr_b` hold the unsigned 16-bit product of the voltage code and the current code present at their sample edges. Input values at any other time do not affect them.
- R4: `mode_vld` pulses high for exactly one cycle, on the edge after snapshot B: the 202nd edge after reset release, then every 256 edges. It is low at all other times.
- R5: If the two powers are equal and the voltages differ, the decision is buck-boost (2'b11).
- R6: If voltage rose (B greater than A), a fall in power gives buck (2'b01) and a rise in power gives boost (2'b10).
- R7: If voltage did not rise (B less than or equal to A), a rise in power gives buck (2'b01) and a fall in power gives boost (2'b10). This includes a voltage code that wraps from 255 to 0.
- R8: If both the powers and the voltages are equal, the previous mode is kept at the strobe.
- R9: `mode` changes only on the cycle in which `mode_vld` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| volt_code | input | 8 | Panel voltage code |
| curr_code | input | 8 | Panel current code |
| mode | output | 2 | Converter mode decision |
| pwr_a | output | 16 | Power at snapshot A |
| pwr_b | output | 16 | Power at snapshot B |
| mode_vld | output | 1 | One-cycle strobe marking a new decision |

## Verification
The assertions assume that the sensor codes are known values, never X, at the two sample edges. They also assume that the sample points keep the order A < B, with B + 2 below the counter wrap. Under these assumptions the snapshot registers are stable between captures, and the decision registers see settled operands. The bench changes the codes only midway between clock edges and uses the default sample points. Between the two captures it drives deliberately different filler codes, so any sampling outside the two counts would corrupt the stored powers.

// File: rtl/mppt_pkg.sv
package mppt_pkg;
  typedef enum logic [1:0] {
    MODE_NONE  = 2'b00,
    MODE_BUCK  = 2'b01,
    MODE_BOOST = 2'b10,
    MODE_BB    = 2'b11
  } mppt_mode_e;
endpackage

// File: rtl/mppt_sample_ctr.sv
module mppt_sample_ctr #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  // R2
  ctr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX) |=> (cnt == '0));
  // R2
  ctr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != CNT_MAX) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/mppt_snapshot.sv
module mppt_snapshot #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PWR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [DATA_W-1:0] volt,
  input  logic [DATA_W-1:0] curr,
  output logic [DATA_W-1:0] v_q,
  output logic [PWR_W-1:0]  p_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= '0;
      p_q <= '0;
    end else if (take) begin
      v_q <= volt;
      p_q <= PWR_W'(volt) * PWR_W'(curr);
    end
  end

  // R3
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> ($stable(p_q) && $stable(v_q)));
endmodule

// File: rtl/mppt_mode_decider.sv
module mppt_mode_decider
  import mppt_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PWR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [DATA_W-1:0] v_a,
  input  logic [PWR_W-1:0]  p_a,
  input  logic [DATA_W-1:0] v_b,
  input  logic [PWR_W-1:0]  p_b,
  output mppt_mode_e        mode,
  output logic              vld
);
  logic       pend;
  logic       p_eq, p_up, v_eq, v_up;
  mppt_mode_e mode_nxt;

  assign p_eq = (p_b == p_a);
  assign p_up = (p_b >  p_a);
  assign v_eq = (v_b == v_a);
  assign v_up = (v_b >  v_a);

  always_comb begin
    if (p_eq)      mode_nxt = v_eq ? mode : MODE_BB;
    else if (p_up) mode_nxt = v_up ? MODE_BOOST : MODE_BUCK;
    else           mode_nxt = v_up ? MODE_BUCK  : MODE_BOOST;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      vld  <= 1'b0;
      mode <= MODE_NONE;
    end else begin
      pend <= trig;
      vld  <= pend;
      if (pend) mode <= mode_nxt;
    end
  end

  // R4
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);
  // R9
  mode_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld |-> (mode == $past(mode)));
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && p_eq && v_eq) |-> (mode == $past(mode)));
  // R5
  mode_bb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && p_eq && !v_eq) |-> (mode == MODE_BB));
endmodule

// File: rtl/mppt_mode_sel.sv
module mppt_mode_sel
  import mppt_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned SAMP_A = 100,
  parameter int unsigned SAMP_B = 200,
  localparam int unsigned PWR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] volt_code,
  input  logic [DATA_W-1:0] curr_code,
  output logic [1:0]        mode,
  output logic [PWR_W-1:0]  pwr_a,
  output logic [PWR_W-1:0]  pwr_b,
  output logic              mode_vld
);
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] v_snap [2];
  logic [PWR_W-1:0]  p_snap [2];
  mppt_mode_e        mode_e;

  mppt_sample_ctr #(.CNT_W(CNT_W)) ctr_i (
    .clk(clk), .rst_n(rst_n), .cnt(cnt)
  );

  for (genvar g = 0; g < 2; g++) begin : g_snap
    localparam int unsigned PT = (g == 0) ? SAMP_A : SAMP_B;
    mppt_snapshot #(.DATA_W(DATA_W)) snap_i (
      .clk(clk), .rst_n(rst_n),
      .take(cnt == CNT_W'(PT)),
      .volt(volt_code), .curr(curr_code),
      .v_q(v_snap[g]), .p_q(p_snap[g])
    );
  end

  mppt_mode_decider #(.DATA_W(DATA_W)) dec_i (
    .clk(clk), .rst_n(rst_n),
    .trig(cnt == CNT_W'(SAMP_B)),
    .v_a(v_snap[0]), .p_a(p_snap[0]),
    .v_b(v_snap[1]), .p_b(p_snap[1]),
    .mode(mode_e), .vld(mode_vld)
  );

  assign mode  = mode_e;
  assign pwr_a = p_snap[0];
  assign pwr_b = p_snap[1];

  // R4
  vld_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_vld |-> (cnt == CNT_W'(SAMP_B + 2)));
  // R2
  pwr_b_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != CNT_W'(SAMP_B + 1)) |-> $stable(pwr_b));
endmodule

// File: tb/mppt_mode_sel_tb.sv
module mppt_mode_sel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  volt_code = '0, curr_code = '0;
  logic [1:0]  mode;
  logic [15:0] pwr_a, pwr_b;
  logic        mode_vld;
  int          n_chk = 0, n_fail = 0;
  logic [1:0]  cur_mode = 2'b00;
  logic [15:0] cur_pa = '0;

  always #4 clk = ~clk;

  mppt_mode_sel dut_i (
    .clk(clk), .rst_n(rst_n), .volt_code(volt_code), .curr_code(curr_code),
    .mode(mode), .pwr_a(pwr_a), .pwr_b(pwr_b), .mode_vld(mode_vld)
  );

  // va, ia, vb, ib, expected mode
  localparam int NV = 11;
  localparam logic [33:0] VEC [NV] = '{
    {8'd10,  8'd50,  8'd20,  8'd20,  2'b01},
    {8'd40,  8'd7,   8'd40,  8'd7,   2'b01},
    {8'd10,  8'd10,  8'd20,  8'd10,  2'b10},
    {8'd20,  8'd10,  8'd10,  8'd30,  2'b01},
    {8'd20,  8'd20,  8'd10,  8'd10,  2'b10},
    {8'd3,   8'd3,   8'd3,   8'd3,   2'b10},
    {8'd20,  8'd10,  8'd10,  8'd20,  2'b11},
    {8'd255, 8'd255, 8'd255, 8'd254, 2'b10},
    {8'd100, 8'd1,   8'd100, 8'd2,   2'b01},
    {8'd255, 8'd1,   8'd0,   8'd200, 2'b10},
    {8'd0,   8'd0,   8'd0,   8'd0,   2'b10}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic run_round(input logic [33:0] v, input int pre);
    logic [7:0]  va, ia, vb, ib;
    logic [15:0] pa, pb;
    string       tag;
    {va, ia, vb, ib} = v[33:2];
    pa = 16'(va) * 16'(ia);
    pb = 16'(vb) * 16'(ib);
    if (pa == pb)   tag = (va == vb) ? "R8" : "R5";
    else if (vb > va) tag = "R6";
    else            tag = "R7";
    volt_code = va; curr_code = ia;
    step(pre - 1);
    check("R2", "pwr_a before sample edge", pwr_a, cur_pa);
    step(1);
    check("R2", "pwr_a at sample edge", pwr_a, pa);
    volt_code = 8'hFF; curr_code = 8'hFF;
    step(50);
    check("R4", "strobe between samples", mode_vld, 0);
    check("R9", "mode between strobes", mode, cur_mode);
    volt_code = vb; curr_code = ib;
    step(50);
    check("R3", "pwr_a ignores filler", pwr_a, pa);
    check("R3", "pwr_b product", pwr_b, pb);
    check("R4", "strobe before decision", mode_vld, 0);
    volt_code = 8'h5A; curr_code = 8'hC3;
    step(1);
    check("R4", "strobe at decision", mode_vld, 1);
    check(tag, "mode", mode, v[1:0]);
    step(1);
    check("R4", "strobe one cycle", mode_vld, 0);
    check("R3", "pwr_b ignores later input", pwr_b, pb);
    cur_mode = v[1:0];
    cur_pa   = pa;
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #2;
    check("R1", "reset mode", mode, 0);
    check("R1", "reset strobe", mode_vld, 0);
    check("R1", "reset pwr_a", pwr_a, 0);
    check("R1", "reset pwr_b", pwr_b, 0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_round(VEC[i], (i == 0) ? 101 : 154);
    // mid-period reset, then the counter must restart from 0
    step(30);
    rst_n = 1'b0;
    step(2);
    check("R1", "mid reset mode", mode, 0);
    check("R1", "mid reset strobe", mode_vld, 0);
    check("R1", "mid reset pwr_a", pwr_a, 0);
    check("R1", "mid reset pwr_b", pwr_b, 0);
    cur_mode = 2'b00; cur_pa = '0;
    rst_n = 1'b1;
    run_round(VEC[2], 101);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule